// File: doc/BRIEF.md
# Maskable Status Event Aggregator

This block gathers a set of independent status conditions into one status word and one interrupt line. Each condition is first passed through a two-stage synchronizer. A per-source sensitivity setting then decides what the status bit records. In level mode the bit follows the live condition. In rising-edge or falling-edge mode the bit latches on the chosen transition and holds until software reads the status word. A per-source pass mask decides which status bits may drive the interrupt. The interrupt is the registered OR of every status bit whose pass bit is set.

Software reaches the block over a simple parallel register bus with separate write and read strobes. Reads return data one cycle after the strobe. A read of the status word returns its value as it was before the read. The same read clears every latched edge bit, except a bit whose edge lands in that very cycle. That edge is kept, so no event is lost.

Each per-source status cell is a two-state machine with the states `CELL_IDLE` (bit clear) and `CELL_HELD` (bit set). It has these transitions:
- **set**, IDLE to HELD: the condition is active in level mode, or the selected edge occurs in an edge mode.
- **drop**, HELD to IDLE: the condition is inactive in level mode.
- **clear**, HELD to IDLE: a status read in an edge mode with no new edge in the same cycle.
- **hold**, HELD to HELD: all other cases.

Each bus cycle is classified by the access decoder as `ACC_IDLE`, `ACC_WRITE`, `ACC_READ` or `ACC_BOTH`.

Top module: `stat_evt_agg`

## Requirements
- R1: After reset the status word, the pass mask, the mode register, the read data and the interrupt are all zero.
- R2: Register map with 4-bit addresses:
  - Pass mask at 0x1, bit i for source i.
  - Mode register at 0x2, bits [2i+1:2i] for source i.
  - Status word at 0x0D, bit i for source i. It is read-only, and a write to it has no effect.
  - Read data appears the cycle after the read strobe. A read of any other address returns zero.
- R3: Mode code 01 (rising) sets a status bit when the synchronized condition goes from 0 to 1. The bit stays set after the condition returns low, until a status read.
- R4: Mode code 10 (falling) sets a status bit when the synchronized condition goes from 1 to 0. The bit stays set until a status read.
- R5: Mode codes 00 and 11 (level) make the status bit follow the synchronized condition. A status read does not clear such a bit.
- R6: A status read returns the word as it was before the read and clears every latched edge bit.
- R7: An edge whose capture coincides with a clearing status read is kept. It appears in the following read.
- R8: The interrupt is the registered OR of the status bits whose pass bit is 1. A source with pass bit 0 still shows in the status word but never raises the interrupt.
- R9: A condition change sampled at rising edge k shows in the status word after edge k+2 and on the interrupt after edge k+3. A pulse that spans one rising clock edge is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw status conditions, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 2*NUM_SRC | Write data |
| rd_data_o | output | 2*NUM_SRC | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Interrupt, registered |

## Verification
The bench aims an edge at the exact cycle in which a clearing read takes effect. A design that let the clear win would lose that event, and the second read would come back empty. It sends a one-cycle pulse and then checks that the edge bit survives the pulse's end and a write to the read-only status address. It also checks that the bit clears only on a read. A design that treated the bit as level, or decoded the write, would show a different value. Cycle-exact reads around a condition change expose a synchronizer or interrupt stage that is missing or extra. Mixed-mode vectors with reserved code 11 and a zero pass mask catch a wrong mode decode, and catch masking applied to the status word instead of to the interrupt.

// File: rtl/sea_pkg.sv
package sea_pkg;

    typedef enum logic [1:0] {
        SENS_LEVEL     = 2'b00,
        SENS_RISE      = 2'b01,
        SENS_FALL      = 2'b10,
        SENS_LEVEL_ALT = 2'b11
    } sens_e;

    typedef enum logic {
        CELL_IDLE = 1'b0,
        CELL_HELD = 1'b1
    } cell_state_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_READ  = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;

endpackage

// File: rtl/sea_sync.sv
module sea_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;

endmodule

// File: rtl/sea_cell.sv
module sea_cell
    import sea_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sync_i,
    input  sens_e mode_i,
    input  logic  clr_i,
    output logic  held_o
);

    cell_state_e state_q;
    cell_state_e state_d;
    logic        prev_q;
    logic        rise;
    logic        fall;
    logic        evt;
    logic        lvl;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_i;
        end
    end

    assign rise = sync_i & ~prev_q;
    assign fall = ~sync_i & prev_q;

    always_comb begin
        evt = 1'b0;
        lvl = 1'b0;
        unique case (mode_i)
            SENS_RISE:      evt = rise;
            SENS_FALL:      evt = fall;
            SENS_LEVEL:     lvl = 1'b1;
            SENS_LEVEL_ALT: lvl = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CELL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: set, drop, clear, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (lvl ? sync_i : evt) begin
                    state_d = CELL_HELD;
                end
            end
            CELL_HELD: begin
                if (lvl) begin
                    if (!sync_i) begin
                        state_d = CELL_IDLE;
                    end
                end else if (clr_i && !evt) begin
                    state_d = CELL_IDLE;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        held_o = (state_q == CELL_HELD);
    end

    a_r7_edge_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lvl && evt) |=> (state_q == CELL_HELD));

    a_r3_sticky_until_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lvl && state_q == CELL_HELD && !clr_i) |=> (state_q == CELL_HELD));

    a_r5_level_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lvl |=> (held_o == $past(sync_i)));

endmodule

// File: rtl/sea_regs.sv
module sea_regs
    import sea_pkg::*;
#(
    parameter int                NUM_SRC   = 8,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] PASS_ADDR = 4'h1,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h2,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'hD
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic                   rd_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [2*NUM_SRC-1:0]   wr_data_i,
    input  logic [NUM_SRC-1:0]     status_i,
    output logic [NUM_SRC-1:0]     pass_o,
    output logic [2*NUM_SRC-1:0]   mode_o,
    output logic                   clr_o,
    output logic [2*NUM_SRC-1:0]   rd_data_o
);

    localparam int DW = 2 * NUM_SRC;

    acc_e              acc;
    logic              do_wr;
    logic              do_rd;
    logic [NUM_SRC-1:0] pass_q;
    logic [DW-1:0]     mode_q;
    logic [DW-1:0]     rd_mux;
    logic [DW-1:0]     rd_q;

    assign acc = acc_e'({rd_en_i, wr_en_i});

    always_comb begin
        do_wr = 1'b0;
        do_rd = 1'b0;
        unique case (acc)
            ACC_IDLE:  ;
            ACC_WRITE: do_wr = 1'b1;
            ACC_READ:  do_rd = 1'b1;
            ACC_BOTH: begin
                do_wr = 1'b1;
                do_rd = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pass_q <= '0;
            mode_q <= '0;
        end else if (do_wr) begin
            if (addr_i == PASS_ADDR) begin
                pass_q <= wr_data_i[NUM_SRC-1:0];
            end else if (addr_i == MODE_ADDR) begin
                mode_q <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (addr_i == PASS_ADDR) begin
            rd_mux = {{NUM_SRC{1'b0}}, pass_q};
        end else if (addr_i == MODE_ADDR) begin
            rd_mux = mode_q;
        end else if (addr_i == STAT_ADDR) begin
            rd_mux = {{NUM_SRC{1'b0}}, status_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else if (do_rd) begin
            rd_q <= rd_mux;
        end
    end

    assign pass_o    = pass_q;
    assign mode_o    = mode_q;
    assign clr_o     = do_rd && (addr_i == STAT_ADDR);
    assign rd_data_o = rd_q;

    a_r6_read_snapshot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == STAT_ADDR) |=> (rd_data_o == {{NUM_SRC{1'b0}}, $past(status_i)}));

    a_r2_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i != STAT_ADDR && addr_i != PASS_ADDR && addr_i != MODE_ADDR)
        |=> (rd_data_o == '0));

endmodule

// File: rtl/stat_evt_agg.sv
module stat_evt_agg
    import sea_pkg::*;
#(
    parameter int                NUM_SRC   = 8,
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] PASS_ADDR = 4'h1,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 4'h2,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 4'hD
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC-1:0]   src_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [2*NUM_SRC-1:0] wr_data_i,
    output logic [2*NUM_SRC-1:0] rd_data_o,
    output logic                 irq_o
);

    localparam int DW = 2 * NUM_SRC;

    logic [NUM_SRC-1:0] sync_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] pass_w;
    logic [DW-1:0]      mode_w;
    logic               clr_w;
    logic               irq_q;

    sea_sync #(.WIDTH(NUM_SRC)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (src_i),
        .q_o    (sync_w)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        sea_cell u_cell (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .sync_i (sync_w[i]),
            .mode_i (sens_e'(mode_w[2*i +: 2])),
            .clr_i  (clr_w),
            .held_o (status_w[i])
        );
    end

    sea_regs #(
        .NUM_SRC   (NUM_SRC),
        .ADDR_W    (ADDR_W),
        .PASS_ADDR (PASS_ADDR),
        .MODE_ADDR (MODE_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wr_data_i (wr_data_i),
        .status_i  (status_w),
        .pass_o    (pass_w),
        .mode_o    (mode_w),
        .clr_o     (clr_w),
        .rd_data_o (rd_data_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(status_w & pass_w);
        end
    end

    assign irq_o = irq_q;

    a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pass_w == '0) |=> !irq_o);

    a_r8_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(|status_w));

endmodule

// File: tb/sim_stat_evt_agg.sv
`timescale 1ns/1ps
module sim_stat_evt_agg;

    localparam int N  = 8;
    localparam int DW = 2 * N;
    localparam logic [3:0] A_PASS = 4'h1;
    localparam logic [3:0] A_MODE = 4'h2;
    localparam logic [3:0] A_STAT = 4'hD;

    // {mode[15:0], pass[7:0], before[7:0], after[7:0]}
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {16'h0000, 8'hFF, 8'h00, 8'hA5},   // R5 all level
        {16'h5555, 8'hFF, 8'h0F, 8'h3C},   // R3 all rising
        {16'hAAAA, 8'hFF, 8'h0F, 8'h3C},   // R4 all falling
        {16'hE4E4, 8'h0F, 8'h55, 8'h3A},   // R5 mixed incl code 11
        {16'h5555, 8'h00, 8'h00, 8'hFF},   // R8 all masked
        {16'h5555, 8'h80, 8'h00, 8'h01}    // R8 partial pass
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [3:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int tests  = 0;
    int failed = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    stat_evt_agg u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .src_i     (src),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .rd_data_o (rdata),
        .irq_o     (irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [DW-1:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    function automatic logic [N-1:0] model(input logic [DW-1:0] m, input logic [N-1:0] b,
                                           input logic [N-1:0] a);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            case (m[2*i +: 2])
                2'b01:   r[i] = ~b[i] & a[i];
                2'b10:   r[i] = b[i] & ~a[i];
                default: r[i] = a[i];
            endcase
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failed++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [N-1:0]  exp_s;

        step(3);
        check("R1 irq in reset", {15'b0, irq}, '0);
        rst_n = 1'b1;
        step(2);
        check("R1 rdata after reset", rdata, '0);
        reg_read(A_PASS, d); check("R1 pass reset", d, '0);
        reg_read(A_MODE, d); check("R1 mode reset", d, '0);
        reg_read(A_STAT, d); check("R1 status reset", d, '0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [DW-1:0] m;
            logic [N-1:0]  p, b, a;
            {m, p, b, a} = VEC[v];
            reg_write(A_MODE, m);
            reg_write(A_PASS, {8'h00, p});
            src = b;
            step(5);
            reg_read(A_STAT, d);
            src = a;
            step(5);
            exp_s = model(m, b, a);
            check($sformatf("R8 vec%0d irq", v), {15'b0, irq}, {15'b0, |(exp_s & p)});
            reg_read(A_STAT, d);
            check($sformatf("R3/R4/R5 vec%0d status", v), d, {8'h00, exp_s});
        end

        // R2 readback and unmapped
        reg_read(A_MODE, d); check("R2 mode readback", d, 16'h5555);
        reg_read(A_PASS, d); check("R2 pass readback", d, 16'h0080);
        reg_read(4'h5, d);   check("R2 unmapped read", d, '0);

        // R6 edge bit cleared by read, level not cleared
        reg_write(A_MODE, 16'h0001);   // src0 rising, rest level
        reg_write(A_PASS, 16'h00FF);
        src = 8'h00;
        step(5);
        reg_read(A_STAT, d);
        src = 8'h03;
        step(5);
        reg_read(A_STAT, d); check("R6 snapshot before clear", d, 16'h0003);
        reg_read(A_STAT, d); check("R6 edge cleared level kept", d, 16'h0002);

        // R7 edge coinciding with clearing read
        reg_write(A_MODE, 16'h5555);
        src = 8'h00;
        step(5);
        reg_read(A_STAT, d);
        src = 8'h02;
        step(5);
        src = 8'h03;
        step(2);
        reg_read(A_STAT, d); check("R7 read returns older bit", d, 16'h0002);
        reg_read(A_STAT, d); check("R7 coincident edge kept", d, 16'h0001);
        reg_read(A_STAT, d); check("R7 cleared afterwards", d, 16'h0000);

        // R9 one-cycle pulse, R2 write to status ignored, R3 sticky
        src = 8'h00;
        step(5);
        reg_read(A_STAT, d);
        src = 8'h04;
        step(1);
        src = 8'h00;
        step(5);
        reg_write(A_STAT, 16'hFFFF);
        reg_read(A_STAT, d); check("R2/R9 pulse held, status write ignored", d, 16'h0004);
        reg_read(A_STAT, d); check("R3 cleared after read", d, 16'h0000);

        // R9 latency, level mode
        reg_write(A_MODE, 16'h0000);
        reg_write(A_PASS, 16'h0001);
        src = 8'h00;
        step(5);
        src = 8'h01;
        step(2);
        reg_read(A_STAT, d); check("R9 status not yet after k+1", d, 16'h0000);
        check("R9 irq low after k+2", {15'b0, irq}, '0);
        reg_read(A_STAT, d); check("R9 status after k+2", d, 16'h0001);
        check("R9 irq after k+3", {15'b0, irq}, 16'h0001);
        src = 8'h00;
        step(5);
        check("R5 level drop irq", {15'b0, irq}, '0);
        reg_read(A_STAT, d); check("R5 level drop status", d, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule